// File: doc/BRIEF.md
# Four-Image Boot Slot Manager

This controller supervises four firmware image slots: a working image, a backup, an archive and a fallback. It decides which slot the next boot runs from. It decides which slot may be written at any moment. It also sequences the two image-to-image copies the scheme needs: working to backup, and backup to archive. Two physical straps and an administrator stop request shape the boot. External logic supplies the image comparison, the integrity test results, the archive period ticks and the copy engine handshake. All of these reach the block as plain pulses or levels.

A working-image update is granted only while the backup holds an exact, valid copy of the current working image. A successful update must pass its tests, survive a reboot and pass its tests again. Only then is it copied into the backup. The archive is refreshed only by a timed copy, and only from a backup that has stayed unchanged for a whole period. The fallback slot is reached only through its strap, and nothing ever writes it.

Top module: `boot_slot_mgr`

## Requirements
- R1: After reset, boot_slot_o is 0 (working), boot_stop_o is 0, wr_en_o is 0, copy_start_o is 0 and slot_valid_o is 4'b1111.
- R2: One cycle after a boot_req_i pulse, boot_slot_o is 3 (fallback) when strap_fb_i is high and 0 (working) otherwise. The slot encoding is 0 working, 1 backup, 2 archive, 3 fallback. Codes 1 and 2 never appear on boot_slot_o.
- R3: When strap_fb_i and strap_stop_i are both high at a boot, the fallback strap wins: boot_slot_o is 3 and boot_stop_o is 0.
- R4: At a boot without the fallback strap, boot_stop_o is set if strap_stop_i is high or an admin_stop_i pulse arrived since the previous boot. An admin request covers that one boot only.
- R5: wr_en_o (bit n enables slot n) never has bit 3 set and never has more than one bit set.
- R6: An upd_req_i sets wr_en_o to 4'b0001 on the next cycle, but only when cmp_eq_i is high, the backup is valid and no copy is running or due. Otherwise the request has no effect.
- R7: After upd_done_i, a test_pass_i pulse, then a boot_req_i pulse, then a second test_pass_i, the block starts a copy with copy_src_o=0 and copy_dst_o=1. A pass seen before the reboot does not start it.
- R8: A test_fail_i pulse during the update sequence abandons it, and no working-to-backup copy follows.
- R9: Once the backup has been valid and unchanged for ARCH_TICKS arch_tick_i pulses, a copy with copy_src_o=1 and copy_dst_o=2 starts. It runs once per backup content, and it is the only way wr_en_o bit 2 is ever set.
- R10: Rewriting the backup restarts the archive period from zero.
- R11: A copy marks its destination invalid in slot_valid_o from its start. copy_abort_i leaves it invalid, and only a later copy_done_i sets it valid again. An aborted archive copy is retried after a fresh full period.
- R12: While a copy runs, wr_en_o has exactly the destination bit set and no new copy or update starts. A one-cycle copy_start_o pulse marks the start of each copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_stop_i | input | 1 | Strap: halt boot at command state |
| strap_fb_i | input | 1 | Strap: boot the fallback image |
| admin_stop_i | input | 1 | Pulse: stop at command state on the next boot |
| boot_req_i | input | 1 | Pulse: a boot takes place |
| upd_req_i | input | 1 | Pulse: request to reprogram the working image |
| cmp_eq_i | input | 1 | Backup compares equal to working image |
| upd_done_i | input | 1 | Pulse: working image programming finished |
| test_pass_i | input | 1 | Pulse: integrity tests passed |
| test_fail_i | input | 1 | Pulse: integrity tests failed |
| arch_tick_i | input | 1 | Pulse: one archive period tick |
| copy_done_i | input | 1 | Pulse: copy engine finished |
| copy_abort_i | input | 1 | Pulse: copy engine interrupted |
| boot_slot_o | output | 2 | Selected boot slot |
| boot_stop_o | output | 1 | Stop at command state for this boot |
| wr_en_o | output | 4 | Per-slot write enable |
| copy_start_o | output | 1 | One-cycle copy start |
| copy_src_o | output | 2 | Copy source slot |
| copy_dst_o | output | 2 | Copy destination slot |
| slot_valid_o | output | 4 | Per-slot content valid |

## Verification
Every cycle, the assertions check several invariants. At most one slot is writable and the fallback never is. Backup and archive codes never reach the boot output. A working-image write opens only after an equal comparison. An archive write happens only with the backup as source. An aborted copy leaves its destination invalid, and the timer count stays bounded. Some properties only the bench scenarios can show. Among them are the strap and admin-request combinations at each boot and the full update-test-reboot-test ordering. The others are the restart of the archive period on a backup rewrite, the retry after an aborted archive copy, and the single archive per backup content.

// File: rtl/bsm_pkg.sv
package bsm_pkg;
  localparam int SLOT_W = 2;
  localparam int NSLOT  = 4;
  typedef enum logic [SLOT_W-1:0] {
    SL_WORK = 2'd0,
    SL_BKUP = 2'd1,
    SL_ARCH = 2'd2,
    SL_FALL = 2'd3
  } slot_e;
endpackage

// File: rtl/bsm_boot_sel.sv
module bsm_boot_sel
  import bsm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  strap_stop_i,
  input  logic  strap_fb_i,
  input  logic  admin_stop_i,
  input  logic  boot_req_i,
  output slot_e slot_o,
  output logic  stop_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      slot_o <= SL_WORK;
      stop_o <= 1'b0;
    end else begin
      if (admin_stop_i)    pend_q <= 1'b1;
      else if (boot_req_i) pend_q <= 1'b0;
      if (boot_req_i) begin
        slot_o <= strap_fb_i ? SL_FALL : SL_WORK;
        stop_o <= !strap_fb_i && (strap_stop_i || pend_q);
      end
    end
  end

  // R2
  boot_slot_role_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_o == SL_WORK) || (slot_o == SL_FALL));
  // R3
  fb_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_req_i && strap_fb_i |=> (slot_o == SL_FALL) && !stop_o);
endmodule

// File: rtl/bsm_arch_timer.sv
module bsm_arch_timer #(
  parameter int ARCH_TICKS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic bkp_busy_i,
  input  logic bkp_grant_i,
  input  logic arch_grant_i,
  input  logic arch_abort_i,
  input  logic bkp_valid_i,
  output logic due_o
);
  localparam int CW = $clog2(ARCH_TICKS + 1);
  localparam logic [CW-1:0] LIM = CW'(ARCH_TICKS);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (bkp_grant_i || bkp_busy_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (arch_grant_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (arch_abort_i) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (tick_i && cnt_q != LIM) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign due_o = armed_q && bkp_valid_i && (cnt_q == LIM);

  // R9
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIM);
endmodule

// File: rtl/bsm_copy_ctl.sv
module bsm_copy_ctl
  import bsm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_wb_i,
  input  logic             req_ba_i,
  input  logic             done_i,
  input  logic             abort_i,
  output logic             grant_wb_o,
  output logic             grant_ba_o,
  output logic             busy_o,
  output logic             start_o,
  output slot_e            src_o,
  output slot_e            dst_o,
  output logic [NSLOT-1:0] wr_en_o,
  output logic [NSLOT-1:0] valid_o
);
  assign grant_wb_o = !busy_o && req_wb_i;
  assign grant_ba_o = !busy_o && req_ba_i && !req_wb_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      start_o <= 1'b0;
      src_o   <= SL_WORK;
      dst_o   <= SL_BKUP;
      valid_o <= '1;
    end else begin
      start_o <= grant_wb_o || grant_ba_o;
      if (grant_wb_o) begin
        busy_o <= 1'b1;
        src_o  <= SL_WORK;
        dst_o  <= SL_BKUP;
        valid_o[SL_BKUP] <= 1'b0;
      end else if (grant_ba_o) begin
        busy_o <= 1'b1;
        src_o  <= SL_BKUP;
        dst_o  <= SL_ARCH;
        valid_o[SL_ARCH] <= 1'b0;
      end else if (busy_o && done_i) begin
        busy_o <= 1'b0;
        valid_o[dst_o] <= 1'b1;
      end else if (busy_o && abort_i) begin
        busy_o <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_wr
    assign wr_en_o[g] = busy_o && (dst_o == slot_e'(g));
  end

  // R12
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);
  // R11
  abort_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && abort_i && !done_i |=> !valid_o[dst_o]);
endmodule

// File: rtl/boot_slot_mgr.sv
module boot_slot_mgr
  import bsm_pkg::*;
#(
  parameter int ARCH_TICKS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strap_stop_i,
  input  logic              strap_fb_i,
  input  logic              admin_stop_i,
  input  logic              boot_req_i,
  input  logic              upd_req_i,
  input  logic              cmp_eq_i,
  input  logic              upd_done_i,
  input  logic              test_pass_i,
  input  logic              test_fail_i,
  input  logic              arch_tick_i,
  input  logic              copy_done_i,
  input  logic              copy_abort_i,
  output logic [SLOT_W-1:0] boot_slot_o,
  output logic              boot_stop_o,
  output logic [NSLOT-1:0]  wr_en_o,
  output logic              copy_start_o,
  output logic [SLOT_W-1:0] copy_src_o,
  output logic [SLOT_W-1:0] copy_dst_o,
  output logic [NSLOT-1:0]  slot_valid_o
);
  typedef enum logic [2:0] {
    U_IDLE, U_PROG, U_TEST1, U_BOOT, U_TEST2, U_CPREQ, U_CPRUN
  } upd_e;

  upd_e             st_q, st_d;
  slot_e            boot_slot, src, dst;
  logic             busy, grant_wb, grant_ba, arch_due;
  logic [NSLOT-1:0] cp_wr;

  bsm_boot_sel u_boot (
    .clk_i, .rst_ni, .strap_stop_i, .strap_fb_i, .admin_stop_i, .boot_req_i,
    .slot_o(boot_slot), .stop_o(boot_stop_o)
  );

  bsm_arch_timer #(.ARCH_TICKS(ARCH_TICKS)) u_timer (
    .clk_i, .rst_ni,
    .tick_i       (arch_tick_i),
    .bkp_busy_i   (busy && dst == SL_BKUP),
    .bkp_grant_i  (grant_wb),
    .arch_grant_i (grant_ba),
    .arch_abort_i (busy && dst == SL_ARCH && copy_abort_i && !copy_done_i),
    .bkp_valid_i  (slot_valid_o[SL_BKUP]),
    .due_o        (arch_due)
  );

  bsm_copy_ctl u_copy (
    .clk_i, .rst_ni,
    .req_wb_i   (st_q == U_CPREQ),
    .req_ba_i   (arch_due && st_q == U_IDLE),
    .done_i     (copy_done_i),
    .abort_i    (copy_abort_i),
    .grant_wb_o (grant_wb),
    .grant_ba_o (grant_ba),
    .busy_o     (busy),
    .start_o    (copy_start_o),
    .src_o      (src),
    .dst_o      (dst),
    .wr_en_o    (cp_wr),
    .valid_o    (slot_valid_o)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      U_IDLE:  if (upd_req_i && cmp_eq_i && slot_valid_o[SL_BKUP] && !busy && !arch_due)
                 st_d = U_PROG;
      U_PROG:  if (upd_done_i) st_d = U_TEST1;
      U_TEST1: if (test_fail_i) st_d = U_IDLE;
               else if (test_pass_i) st_d = U_BOOT;
      U_BOOT:  if (boot_req_i) st_d = U_TEST2;
      U_TEST2: if (test_fail_i) st_d = U_IDLE;
               else if (test_pass_i) st_d = U_CPREQ;
      U_CPREQ: if (grant_wb) st_d = U_CPRUN;
      U_CPRUN: if (!busy) st_d = U_IDLE;
      default: st_d = U_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= U_IDLE;
    else         st_q <= st_d;
  end

  assign boot_slot_o = boot_slot;
  assign copy_src_o  = src;
  assign copy_dst_o  = dst;
  assign wr_en_o     = cp_wr | {{(NSLOT-1){1'b0}}, st_q == U_PROG};

  // R5
  one_writer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en_o) && !wr_en_o[SL_FALL]);
  // R6
  upd_after_cmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_en_o[SL_WORK]) |-> $past(cmp_eq_i && upd_req_i));
  // R9
  arch_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o[SL_ARCH] |-> (copy_src_o == SL_BKUP));
endmodule

// File: tb/boot_slot_mgr_tb_top.sv
module boot_slot_mgr_tb_top;
  localparam int AT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic strap_stop = 0, strap_fb = 0, admin_stop = 0, boot_req = 0, upd_req = 0;
  logic cmp_eq = 0, upd_done = 0, test_pass = 0, test_fail = 0, arch_tick = 0;
  logic copy_done = 0, copy_abort = 0;
  logic [1:0] boot_slot, copy_src, copy_dst;
  logic [3:0] wr_en, slot_valid;
  logic boot_stop, copy_start;
  int total = 0, bad = 0, n_start = 0;

  always #2 clk = ~clk;

  boot_slot_mgr #(.ARCH_TICKS(AT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .strap_stop_i(strap_stop), .strap_fb_i(strap_fb),
    .admin_stop_i(admin_stop), .boot_req_i(boot_req), .upd_req_i(upd_req),
    .cmp_eq_i(cmp_eq), .upd_done_i(upd_done), .test_pass_i(test_pass),
    .test_fail_i(test_fail), .arch_tick_i(arch_tick), .copy_done_i(copy_done),
    .copy_abort_i(copy_abort), .boot_slot_o(boot_slot), .boot_stop_o(boot_stop),
    .wr_en_o(wr_en), .copy_start_o(copy_start), .copy_src_o(copy_src),
    .copy_dst_o(copy_dst), .slot_valid_o(slot_valid)
  );

  always @(posedge clk) if (rst_n && copy_start) n_start++;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_boot();
    boot_req = 1; cyc(1); boot_req = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      arch_tick = 1; cyc(1); arch_tick = 0; cyc(1);
    end
  endtask

  task automatic wait_start(input string req, input int es, input int ed);
    int found = 0;
    for (int i = 0; i < 6 && found == 0; i++) begin
      if (copy_start) begin
        found = 1;
        chk(req, copy_src, es);
        chk(req, copy_dst, ed);
      end else cyc(1);
    end
    chk(req, found, 1);
  endtask

  initial begin
    int base;
    cyc(2);
    rst_n = 1;
    cyc(1);
    // R1
    chk("R1 slot", boot_slot, 0);
    chk("R1 stop", boot_stop, 0);
    chk("R1 wr", wr_en, 0);
    chk("R1 start", copy_start, 0);
    chk("R1 valid", slot_valid, 15);

    // R2 R3 R4 strap and admin sweep
    for (int c = 0; c < 8; c++) begin
      strap_fb = c[0]; strap_stop = c[1];
      if (c[2]) begin admin_stop = 1; cyc(1); admin_stop = 0; end
      do_boot();
      chk("R2 slot", boot_slot, c[0] ? 3 : 0);
      chk(c[0] ? "R3 stop" : "R4 stop", boot_stop, (!c[0] && (c[1] || c[2])) ? 1 : 0);
      do_boot();
      chk("R4 one boot", boot_stop, (!c[0] && c[1]) ? 1 : 0);
    end
    strap_fb = 0; strap_stop = 0;

    // R6 rejected without equal compare
    cmp_eq = 0; upd_req = 1; cyc(1); upd_req = 0;
    chk("R6 no cmp", wr_en, 0);
    cyc(2);
    chk("R6 no cmp later", wr_en, 0);

    tick(3);

    // R8 fail path
    cmp_eq = 1; upd_req = 1; cyc(1); upd_req = 0;
    chk("R6 grant", wr_en, 1);
    upd_done = 1; cyc(1); upd_done = 0;
    chk("R5 wr after done", wr_en, 0);
    test_fail = 1; cyc(1); test_fail = 0;
    base = n_start;
    do_boot();
    test_pass = 1; cyc(1); test_pass = 0;
    cyc(4);
    chk("R8 no copy", n_start - base, 0);
    chk("R8 wr", wr_en, 0);

    // R7 success path
    upd_req = 1; cyc(1); upd_req = 0;
    chk("R6 grant2", wr_en, 1);
    upd_done = 1; cyc(1); upd_done = 0;
    test_pass = 1; cyc(1); test_pass = 0;
    base = n_start;
    test_pass = 1; cyc(1); test_pass = 0;
    cyc(3);
    chk("R7 no copy before reboot", n_start - base, 0);
    do_boot();
    test_pass = 1; cyc(1); test_pass = 0;
    wait_start("R7 start", 0, 1);
    chk("R12 wr backup", wr_en, 2);
    chk("R11 bkp invalid", slot_valid, 13);
    upd_req = 1; cyc(1); upd_req = 0;
    chk("R12 no update in copy", wr_en, 2);
    copy_done = 1; cyc(1); copy_done = 0;
    chk("R11 bkp valid", slot_valid, 15);
    chk("R12 wr idle", wr_en, 0);

    // R10 period restarted by backup rewrite
    base = n_start;
    tick(3);
    cyc(2);
    chk("R10 no early archive", n_start - base, 0);
    tick(1);
    wait_start("R9 start", 1, 2);
    chk("R9 wr archive", wr_en, 4);
    chk("R11 arch invalid", slot_valid, 11);
    copy_abort = 1; cyc(1); copy_abort = 0;
    chk("R11 abort invalid", slot_valid, 11);
    chk("R11 abort wr", wr_en, 0);
    base = n_start;
    tick(3);
    cyc(2);
    chk("R11 retry waits period", n_start - base, 0);
    tick(1);
    wait_start("R11 retry", 1, 2);
    copy_done = 1; cyc(1); copy_done = 0;
    chk("R11 arch valid", slot_valid, 15);
    base = n_start;
    tick(6);
    cyc(2);
    chk("R9 once per backup", n_start - base, 0);
    chk("R5 fallback never written", wr_en, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule